// File: doc/BRIEF.md
# I2C SCL Rate and Setup Timer

This block paces the clock line of an I2C master engine. A pre-divider first turns the peripheral clock into an internal tick. Every SCL interval is then counted in whole ticks. An SCL period is a fixed base of 20 ticks, plus eight ticks for each step of a programmable gap, plus a small programmable rounding count. The rounding count absorbs the rise time, the fall time and the internal delay of the line.

When the engine raises `run`, the block latches its settings and waits a short first-bit setup delay. It then pulls SCL low and alternates low and high phases until `run` is dropped. The low phase takes the larger half of the period. The high phase only counts while the line is actually seen high, so a slave may stretch the clock. The engine steers its data from the one-cycle strobes `scl_fall`, `scl_rise` and `sample`. Working out the settings for a target bus frequency is left to software.

Top module: `i2c_scl_timer`

## Requirements
- R1: While busy, `tick` pulses once every (1 + P) clocks, where P is `div_cfg[2:0]` (0..7).
- R2: One SCL period spans 20 + 8·G + `round_cnt` ticks, where G is `div_cfg[8:3]` (0..63).
- R3: With period T ticks, the low phase lasts ceil(T/2) ticks and the high phase lasts T − ceil(T/2) ticks, provided `scl_in` stays high.
- R4: The first `scl_fall` appears (`setup_cfg` + 2)·(1 + P) clocks after the clock edge that accepts `run` from idle. A `setup_cfg` of 15 gives 17 ticks.
- R5: During the high phase, a tick counts only if `scl_in` is high at it. Each tick that sees `scl_in` low lengthens the high phase.
- R6: `sample` pulses on the first tick of the high phase at which `scl_in` is high.
- R7: `div_cfg`, `round_cnt` and `setup_cfg` are captured only when `run` is accepted from idle. Changing them while busy does not alter any phase length.
- R8: If `run` is low at the end of a high phase, the block returns to idle. `busy` falls, `scl_out` stays high and no further `scl_fall` is produced.
- R9: Synchronous reset forces `scl_out` high, `busy` low and all strobes low.
- R10: The strobes are single-clock pulses that never coincide. `scl_fall` appears in the same cycle that `scl_out` goes low, and `scl_rise` in the same cycle that `scl_out` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Engine requests SCL clocking; sampled at start and at the end of each high phase |
| div_cfg | input | 9 | Divider settings: bits 8:3 gap G, bits 2:0 pre-divider P |
| round_cnt | input | 4 | Rise/fall rounding ticks added to each period |
| setup_cfg | input | 4 | First-bit setup; the delay is this value plus 2 ticks |
| scl_in | input | 1 | Sampled level of the SCL line |
| tick | output | 1 | Internal tick strobe |
| busy | output | 1 | High from acceptance of `run` until the return to idle |
| scl_out | output | 1 | SCL drive level (1 = released) |
| scl_rise | output | 1 | Pulse as SCL is released |
| scl_fall | output | 1 | Pulse as SCL is pulled low |
| sample | output | 1 | Pulse at the first counted high tick |

## Verification
Every result is due a whole number of divided ticks after its trigger, and the bench computes each expected count from the requirement formulas. The first fall is due (setup + 2)·(1 + P) clocks after the accepting edge; the edge itself is counted, so the bench expects one count more. A rise is due ceil(T/2)·(1 + P) clocks after a fall. `sample` is due one tick after a rise. The next fall is due after the remaining high ticks, plus one clock for each stretched clock when P is 0. The bench samples 1 ns after each rising edge and counts edges until the awaited strobe appears, so every check compares an exact clock count with its expected value.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    localparam int PRE_W      = 3;
    localparam int GAP_W      = 6;
    localparam int RND_W      = 4;
    localparam int SET_W      = 4;
    localparam int BASE_TICKS = 20;
    localparam int GAP_STEP   = 8;
    localparam int SETUP_BIAS = 2;
    localparam int MAX_PERIOD = BASE_TICKS + GAP_STEP * ((1 << GAP_W) - 1) + (1 << RND_W) - 1;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    typedef logic [CNT_W-1:0] ticks_t;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [PRE_W-1:0] prediv;
    } div_cfg_t;

    typedef struct packed {
        div_cfg_t         div;
        logic [RND_W-1:0] rnd;
        logic [SET_W-1:0] setup;
    } timing_cfg_t;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_e;

    function automatic ticks_t period_ticks(div_cfg_t d, logic [RND_W-1:0] r);
        return ticks_t'(BASE_TICKS + GAP_STEP * int'(d.gap) + int'(r));
    endfunction

    function automatic ticks_t low_ticks(ticks_t p);
        return ticks_t'((int'(p) + 1) / 2);
    endfunction

    function automatic ticks_t setup_ticks(logic [SET_W-1:0] s);
        return ticks_t'(int'(s) + SETUP_BIAS);
    endfunction
endpackage

// File: rtl/i2c_scl_prescale.sv
module i2c_scl_prescale import i2c_scl_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] prediv,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)          cnt <= '0;
        else if (cnt == prediv)  cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == prediv);

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && en && prediv != '0) |=> !tick);
endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase import i2c_scl_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             scl_in,
    input  logic             tick,
    input  timing_cfg_t      cfg_in,
    output logic [PRE_W-1:0] prediv_q,
    output logic             busy,
    output logic             scl_out,
    output logic             scl_rise,
    output logic             scl_fall,
    output logic             sample
);
    phase_e      state;
    ticks_t      remain;
    timing_cfg_t cfg_q;
    logic        first_hi;
    ticks_t      per, lo_len, hi_len;

    assign per      = period_ticks(cfg_q.div, cfg_q.rnd);
    assign lo_len   = low_ticks(per);
    assign hi_len   = per - lo_len;
    assign busy     = (state != PH_IDLE);
    assign prediv_q = cfg_q.div.prediv;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_IDLE;
            remain   <= '0;
            cfg_q    <= '0;
            first_hi <= 1'b0;
            scl_out  <= 1'b1;
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
            sample   <= 1'b0;
        end else begin
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
            sample   <= 1'b0;
            case (state)
                PH_IDLE: if (run) begin
                    cfg_q  <= cfg_in;
                    remain <= setup_ticks(cfg_in.setup);
                    state  <= PH_SETUP;
                end
                PH_SETUP: if (tick) begin
                    if (remain == ticks_t'(1)) begin
                        state    <= PH_LOW;
                        remain   <= lo_len;
                        scl_out  <= 1'b0;
                        scl_fall <= 1'b1;
                    end else remain <= remain - ticks_t'(1);
                end
                PH_LOW: if (tick) begin
                    if (remain == ticks_t'(1)) begin
                        state    <= PH_HIGH;
                        remain   <= hi_len;
                        scl_out  <= 1'b1;
                        scl_rise <= 1'b1;
                        first_hi <= 1'b1;
                    end else remain <= remain - ticks_t'(1);
                end
                PH_HIGH: if (tick && scl_in) begin
                    first_hi <= 1'b0;
                    sample   <= first_hi;
                    if (remain == ticks_t'(1)) begin
                        if (run) begin
                            state    <= PH_LOW;
                            remain   <= lo_len;
                            scl_out  <= 1'b0;
                            scl_fall <= 1'b1;
                        end else begin
                            state <= PH_IDLE;
                        end
                    end else remain <= remain - ticks_t'(1);
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PH_HIGH && !scl_in) |=> $stable(remain));
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> scl_out);
    assert_fall_from_high_R10: assert property (@(posedge clk) disable iff (rst)
        scl_fall |-> $past(scl_out));
    assert_rise_from_low_R10: assert property (@(posedge clk) disable iff (rst)
        scl_rise |-> !$past(scl_out));
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scl_rise, scl_fall, sample}));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer import i2c_scl_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic [PRE_W+GAP_W-1:0] div_cfg,
    input  logic [RND_W-1:0]       round_cnt,
    input  logic [SET_W-1:0]       setup_cfg,
    input  logic                   scl_in,
    output logic                   tick,
    output logic                   busy,
    output logic                   scl_out,
    output logic                   scl_rise,
    output logic                   scl_fall,
    output logic                   sample
);
    timing_cfg_t      cfg_in;
    logic [PRE_W-1:0] prediv_q;

    assign cfg_in = {div_cfg, round_cnt, setup_cfg};

    i2c_scl_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .en     (busy),
        .prediv (prediv_q),
        .tick   (tick)
    );

    i2c_scl_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .scl_in   (scl_in),
        .tick     (tick),
        .cfg_in   (cfg_in),
        .prediv_q (prediv_q),
        .busy     (busy),
        .scl_out  (scl_out),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sample   (sample)
    );
endmodule

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;
    logic       clk = 1'b0;
    logic       rst, run, stretch;
    logic [8:0] div_cfg;
    logic [3:0] round_cnt, setup_cfg;
    logic       scl_in, tick, busy, scl_out, scl_rise, scl_fall, sample;
    int         checks = 0, fails = 0, fall_cnt = 0;

    always #5 clk = ~clk;
    assign scl_in = scl_out & ~stretch;

    i2c_scl_timer uut (
        .clk(clk), .rst(rst), .run(run), .div_cfg(div_cfg), .round_cnt(round_cnt),
        .setup_cfg(setup_cfg), .scl_in(scl_in), .tick(tick), .busy(busy),
        .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall), .sample(sample)
    );

    always @(negedge clk) if (scl_fall) fall_cnt++;

    // {prediv[16:14], gap[13:8], round[7:4], setup[3:0]}
    localparam logic [16:0] VEC [5] = '{
        {3'd0, 6'd0,  4'd0,  4'd0},
        {3'd1, 6'd1,  4'd3,  4'd15},
        {3'd7, 6'd2,  4'd5,  4'd5},
        {3'd3, 6'd0,  4'd15, 4'd1},
        {3'd0, 6'd63, 4'd15, 4'd0}
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0 fall, 1 rise, 2 sample, 3 idle
    function automatic bit seen(int which);
        case (which)
            0: return scl_fall;
            1: return scl_rise;
            2: return sample;
            default: return !busy;
        endcase
    endfunction

    task automatic wait_for(int which, output int n);
        n = 0;
        forever begin
            @(posedge clk); #1;
            n++;
            if (seen(which)) break;
            if (n > 20000) begin
                check("timeout", n, -1);
                break;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n, fc;
        rst = 1; run = 0; stretch = 0; div_cfg = '0; round_cnt = '0; setup_cfg = '0;
        repeat (3) @(posedge clk); #1;
        check("R9 reset scl_out", int'(scl_out), 1);
        check("R9 reset busy", int'(busy), 0);
        check("R9 reset strobes", int'({scl_rise, scl_fall, sample, tick}), 0);
        @(negedge clk) rst = 0;
        repeat (2) @(posedge clk);

        foreach (VEC[i]) begin
            int d, p, l, h, su;
            d  = int'(VEC[i][16:14]) + 1;
            p  = 20 + 8 * int'(VEC[i][13:8]) + int'(VEC[i][7:4]);
            l  = (p + 1) / 2;
            h  = p - l;
            su = int'(VEC[i][3:0]) + 2;
            @(negedge clk);
            div_cfg = {VEC[i][13:8], VEC[i][16:14]};
            round_cnt = VEC[i][7:4]; setup_cfg = VEC[i][3:0]; run = 1;
            wait_for(0, n); check("R4 setup delay", n, su * d + 1);
            check("R10 scl low with fall", int'(scl_out), 0);
            wait_for(1, n); check("R1 R2 R3 low phase", n, l * d);
            check("R10 scl high with rise", int'(scl_out), 1);
            wait_for(2, n); check("R6 sample offset", n, d);
            fc = n;
            wait_for(0, n); check("R1 R2 R3 high phase", fc + n, h * d);
            wait_for(1, n);
            run = 0; fc = fall_cnt;
            wait_for(3, n); check("R8 stop latency", n, h * d);
            check("R8 no extra fall", fall_cnt, fc);
            check("R8 scl released", int'(scl_out), 1);
        end

        // R7: settings changed mid-run are ignored (period 20: low 10, high 10)
        @(negedge clk);
        div_cfg = '0; round_cnt = '0; setup_cfg = '0; run = 1;
        wait_for(0, n);
        div_cfg = {6'd5, 3'd3}; round_cnt = 4'd9; setup_cfg = 4'd7;
        wait_for(1, n); check("R7 low unchanged", n, 10);
        wait_for(0, n); check("R7 high unchanged", n, 10);
        wait_for(1, n); run = 0;
        wait_for(3, n);

        // R5: stretch 7 clocks after rise, prediv 0, period 20
        @(negedge clk);
        div_cfg = '0; round_cnt = '0; setup_cfg = '0; run = 1;
        wait_for(0, n);
        wait_for(1, n);
        stretch = 1;
        repeat (7) @(posedge clk);
        #1 stretch = 0;
        wait_for(2, n); check("R5 R6 sample after stretch", n + 7, 8);
        fc = n + 7;
        wait_for(0, n); check("R5 stretched high", fc + n, 17);
        run = 0;
        wait_for(3, n);

        // R9: reset in mid-run
        @(negedge clk) run = 1;
        wait_for(0, n);
        @(negedge clk) begin rst = 1; run = 0; end
        @(posedge clk); #1;
        check("R9 mid-run scl_out", int'(scl_out), 1);
        check("R9 mid-run busy", int'(busy), 0);
        @(negedge clk) rst = 0;
        repeat (3) @(posedge clk); #1;
        check("R9 stays idle", int'(busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule